// File: doc/BRIEF.md
# Configurable Status Pin Generator

This block produces the active-low status output of a flash device. Its inputs are the busy flag of the internal write state machine and that machine's one-cycle erase-done and program-done strobes. The pin runs in one of four modes. In level mode it shows ready or busy directly. In the three pulse modes it stays high and drops low for a fixed time when a selected kind of operation completes. In a system, the level mode can hold off a memory controller while the device works. The pulse modes can raise an interrupt for erase completion, program completion, or both.

The mode is set by a two-byte configuration sequence on the byte-wide command write port. The first byte is a configuration command byte (default B8h). The second write supplies the mode code in its two lowest bits. The pulse width is a cycle count derived from the clock frequency and a target width in nanoseconds (250 ns by default). A completion that arrives during a pulse restarts the width count.

Top module: `cfg_status_pin`

## Requirements
- R1: A write of the command byte (B8h) arms configuration. The next write, whatever its value, is consumed as data. Its bits [1:0] become the mode from the clock edge that samples it, and bits [7:2] are ignored. Mode codes: 00 level, 01 pulse on erase, 10 pulse on program, 11 pulse on either.
- R2: After reset the mode is 00 (level) and `sts_n` is high.
- R3: In level mode, `sts_n` equals the inverse of `wsm_busy` sampled one clock earlier.
- R4: In mode 01, an `erase_done` strobe drives `sts_n` low for exactly PULSE_CYC cycles, starting at the edge that samples the strobe. A `prog_done` strobe gives no pulse.
- R5: In mode 10, a `prog_done` strobe gives the same PULSE_CYC-cycle low pulse, and `erase_done` gives none.
- R6: In mode 11, either strobe gives the PULSE_CYC-cycle low pulse.
- R7: A selected strobe that arrives during a pulse restarts the count, so `sts_n` stays low for PULSE_CYC cycles counted from the later strobe.
- R8: In any pulse mode, `sts_n` rests high and `wsm_busy` has no effect on it.
- R9: A write that is neither the command byte nor the data byte that follows it leaves the mode unchanged.
- R10: In level mode, the done strobes have no effect on `sts_n`.
- R11: Writing a configuration ends any pulse in progress, and `sts_n` follows the new mode from the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_we | input | 1 | Command write strobe, one cycle per byte |
| cmd_byte | input | 8 | Byte written with `cmd_we` |
| wsm_busy | input | 1 | Write state machine busy |
| erase_done | input | 1 | One-cycle erase completion strobe |
| prog_done | input | 1 | One-cycle program completion strobe |
| sts_n | output | 1 | Registered active-low status output |

## Verification
On every cycle, the assertions check these behaviours:
- In level mode, the output tracks the previous cycle's busy flag.
- In pulse modes, the output rests high when no selected event arrives, whatever busy does.
- The pulse counter steps down by one per cycle and reloads on a selected event.
- An armed configuration is consumed by the next write, and the mode changes only on that data write.

Other properties can be shown only by the bench's scenarios. These include the exact low-pulse length per mode, which strobe kind each mode selects, restart on a late strobe, reserved-bit masking, a command byte consumed as data, and a pulse cut short by reconfiguration.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    STS_LEVEL = 2'b00,
    STS_ERASE = 2'b01,
    STS_PROG  = 2'b10,
    STS_BOTH  = 2'b11
  } sts_mode_e;
endpackage

// File: rtl/csp_cfg_decode.sv
module csp_cfg_decode
  import csp_pkg::*;
#(
  parameter int unsigned         BYTE_W  = 8,
  parameter logic [BYTE_W-1:0]   CFG_CMD = 8'hB8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output sts_mode_e         mode_q,
  output sts_mode_e         mode_d,
  output logic              cfg_wr
);
  logic armed_q;

  // the write right after the command byte is always data
  assign cfg_wr = armed_q && we;

  always_comb begin
    mode_d = mode_q;
    if (cfg_wr) mode_d = sts_mode_e'(wdata[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      mode_q  <= STS_LEVEL;
    end else begin
      mode_q <= mode_d;
      if (we) armed_q <= !armed_q && (wdata == CFG_CMD);
    end
  end

  // R1: an armed sequence is consumed by the next write
  p_arm_consumed_r1: assert property (@(posedge clk) disable iff (rst)
    (armed_q && we) |=> !armed_q);

  // R9: mode moves only on the data write of a sequence
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(armed_q && we) |=> $stable(mode_q));
endmodule

// File: rtl/csp_pulse_timer.sv
module csp_pulse_timer #(
  parameter int unsigned PULSE_CYC = 25,
  localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic load,
  output logic idle_d
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear)            cnt_d = '0;
    else if (load)        cnt_d = CNT_W'(PULSE_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = '0;
  end

  assign idle_d = (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R4: the count steps down by one per cycle when not reloaded
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load && !clear) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: a selected event restarts the full width
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (cnt_q == CNT_W'(PULSE_CYC)));
endmodule

// File: rtl/cfg_status_pin.sv
module cfg_status_pin
  import csp_pkg::*;
#(
  parameter int unsigned       CLK_MHZ  = 100,
  parameter int unsigned       PULSE_NS = 250,
  parameter logic [7:0]        CFG_CMD  = 8'hB8,
  localparam int unsigned      PULSE_CYC = (PULSE_NS * CLK_MHZ + 999) / 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       wsm_busy,
  input  logic       erase_done,
  input  logic       prog_done,
  output logic       sts_n
);
  sts_mode_e mode_q, mode_d;
  logic      cfg_wr, evt, idle_d, sts_d;

  csp_cfg_decode #(.BYTE_W(8), .CFG_CMD(CFG_CMD)) u_dec (
    .clk(clk), .rst(rst), .we(cmd_we), .wdata(cmd_byte),
    .mode_q(mode_q), .mode_d(mode_d), .cfg_wr(cfg_wr)
  );

  // bit 0 of the mode enables erase, bit 1 enables program
  assign evt = (erase_done && mode_q[0]) || (prog_done && mode_q[1]);

  csp_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clear(cfg_wr), .load(evt), .idle_d(idle_d)
  );

  assign sts_d = (mode_d == STS_LEVEL) ? !wsm_busy : idle_d;

  always_ff @(posedge clk) begin
    if (rst) sts_n <= 1'b1;
    else     sts_n <= sts_d;
  end

  // R3: level mode mirrors busy one cycle later
  p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == STS_LEVEL && !cfg_wr) |=> (sts_n == !$past(wsm_busy)));

  // R8: pulse modes rest high without a selected event
  p_rest_high_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q != STS_LEVEL && sts_n && !evt && !cfg_wr) |=> sts_n);
endmodule

// File: tb/cfg_status_pin_tb.sv
module cfg_status_pin_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 25;

  logic clk = 1'b0, rst = 1'b1, cmd_we = 1'b0, wsm_busy = 1'b0;
  logic erase_done = 1'b0, prog_done = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic sts_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_status_pin u_dut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .wsm_busy(wsm_busy), .erase_done(erase_done), .prog_done(prog_done),
    .sts_n(sts_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    cmd_we = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] data);
    wr(8'hB8);
    wr(data);
  endtask

  task automatic strobe(input logic e, input logic p);
    erase_done = e; prog_done = p;
    @(negedge clk);
    erase_done = 1'b0; prog_done = 1'b0;
  endtask

  // counts low cycles seen from now on
  task automatic measure(output int n);
    n = 0;
    while (sts_n == 1'b0 && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R2 sts_n after reset", sts_n, 1);
    wsm_busy = 1'b1; @(negedge clk);
    check("R2 default mode is level", sts_n, 0);
    wsm_busy = 1'b0; @(negedge clk);
  endtask

  task automatic t_level();
    int n;
    set_mode(8'h00);
    wsm_busy = 1'b1; @(negedge clk);
    check("R3 busy gives low", sts_n, 0);
    wsm_busy = 1'b0; @(negedge clk);
    check("R3 ready gives high", sts_n, 1);
    strobe(1'b1, 1'b1); measure(n);
    check("R10 done strobes ignored in level", n, 0);
  endtask

  task automatic t_erase();
    int n;
    set_mode(8'h01);
    strobe(1'b1, 1'b0); measure(n);
    check("R4 erase pulse width", n, PW);
    strobe(1'b0, 1'b1); measure(n);
    check("R4 program ignored in mode 01", n, 0);
  endtask

  task automatic t_prog();
    int n;
    set_mode(8'h02);
    strobe(1'b0, 1'b1); measure(n);
    check("R5 program pulse width", n, PW);
    strobe(1'b1, 1'b0); measure(n);
    check("R5 erase ignored in mode 10", n, 0);
  endtask

  task automatic t_both();
    int n;
    set_mode(8'h03);
    strobe(1'b1, 1'b0); measure(n);
    check("R6 erase pulse in mode 11", n, PW);
    strobe(1'b0, 1'b1); measure(n);
    check("R6 program pulse in mode 11", n, PW);
  endtask

  task automatic t_retrigger();
    int n;
    set_mode(8'h03);
    strobe(1'b1, 1'b0);
    repeat (9) @(negedge clk);
    check("R7 still low before restart", sts_n, 0);
    strobe(1'b0, 1'b1); measure(n);
    check("R7 width counted from later strobe", n, PW);
  endtask

  task automatic t_busy_ignored();
    set_mode(8'h03);
    wsm_busy = 1'b1; repeat (3) @(negedge clk);
    check("R8 busy ignored in pulse mode", sts_n, 1);
    wsm_busy = 1'b0; @(negedge clk);
  endtask

  task automatic t_reserved();
    int n;
    set_mode(8'hFD);
    strobe(1'b1, 1'b0); measure(n);
    check("R1 bits 7:2 ignored, FDh selects erase", n, PW);
    strobe(1'b0, 1'b1); measure(n);
    check("R1 FDh does not select program", n, 0);
  endtask

  task automatic t_cmd_as_data();
    wr(8'hB8); wr(8'hB8);
    wsm_busy = 1'b1; @(negedge clk);
    check("R1 B8h as data selects level", sts_n, 0);
    wsm_busy = 1'b0;
    wr(8'h03);
    wsm_busy = 1'b1; @(negedge clk);
    check("R9 unarmed write keeps level mode", sts_n, 0);
    wsm_busy = 1'b0; @(negedge clk);
  endtask

  task automatic t_cut_short();
    set_mode(8'h01);
    strobe(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    wr(8'hB8);
    check("R11 pulse running before reconfig", sts_n, 0);
    wr(8'h00);
    check("R11 level mode ends pulse at once", sts_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_level();
    t_erase();
    t_prog();
    t_both();
    t_retrigger();
    t_busy_ignored();
    t_reserved();
    t_cmd_as_data();
    t_cut_short();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule